// File: doc/BRIEF.md
# CompactFlash Host Bridge Controller

This block connects a simple host processor port to a CompactFlash-style card socket that runs in either common memory mode or I/O mode. It watches the two active-low card-detect pins. When the host has enabled the bridge and a card is fully seated, it pulls an active-low interrupt toward the host. The host answers with an acknowledge line. Each rising edge of acknowledge launches exactly one card operation. The bridge decodes the 4-bit host command, together with the mode input and the host address, into card selects, strobes, the register-select line, the 11-bit card address and the card reset line.

A hardware or software reset request from the host is applied when the next acknowledge arrives. A write that sets bit 7 of the option configuration register is also a reset request, and it is applied on the acknowledge that follows the write. The host ready output mirrors card readiness. The 16-bit data bus passes straight between host and card, and only its bit 7 is tapped to spot that software reset. The block has no streaming data path. Every pin is a plain level-controlled signal, and the acknowledge edge is the only pacing.

Top module: `cfb_bridge`

## Requirements
- R1: While host_en is low, host_irq_n is 1, host_rdy is 0, all card selects and strobes are 1, card_reset is 0, and acknowledge edges are ignored.
- R2: host_irq_n is 0 exactly when host_en is 1 and both card_det_n bits are 0, after at most 4 clock cycles of synchronisation.
- R3: Card outputs change only on a rising edge of host_ack, within 4 clock cycles of that edge. Between edges they hold even if command, address or mode change.
- R4: If host_rst (bit 0 hardware, bit 1 software) is nonzero at an update, card_reset goes to 1, all selects and strobes go to 1, and card_addr goes to 0. The next update without a reset request returns card_reset to 0.
- R5: A command 6 (option register write) with host_wd7 = 1 is issued as a normal write. The update that follows drives card_reset to 1 whatever its command is.
- R6: In memory mode (io_mode = 0), data reads (commands 1, 2) pull card_oe_n low and data writes (commands 3, 4) pull card_we_n low, with card_reg_n = 1 and both I/O strobes at 1.
- R7: In I/O mode (io_mode = 1), data reads pull card_iord_n low and data writes pull card_iowr_n low, with card_reg_n = 0 and card_oe_n and card_we_n at 1.
- R8: Byte commands (1, 3) drive card_cs_n = 2'b10 and pass host_addr unchanged. Word commands (2, 4) drive card_cs_n = 2'b00 and card_addr = host_addr with bit 0 cleared.
- R9: The configuration commands work in either mode. They drive card_reg_n = 0 and card_cs_n = 2'b10, and set card_addr to 0x200 (option), 0x202 (status) or 0x204 (pin replacement). Read commands (5, 7, 9) pull card_oe_n low and write commands (6, 8, 10) pull card_we_n low.
- R10: Command encoding: 0 no-op, 1 read byte, 2 read word, 3 write byte, 4 write word, 5/6 option read/write, 7/8 status read/write, 9/10 pin replacement read/write. Codes 0 and 11 to 15 give the idle state: selects and strobes at 1, card_reg_n = 1, card_addr = 0.
- R11: host_rdy follows card_rdy, but is forced to 0 while card_reset is 1, while no card is detected, or while host_en is 0.
- R12: While the card is not fully detected, acknowledge edges are ignored and all card outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Bridge enable from host |
| card_det_n | input | 2 | Active-low card-detect pins |
| host_ack | input | 1 | Host acknowledge; rising edge launches an operation |
| host_cmd | input | 4 | Operation code |
| host_rst | input | 2 | Reset request, bit 0 hardware, bit 1 software |
| io_mode | input | 1 | 0 memory mode, 1 I/O mode |
| host_addr | input | 11 | Card address for data commands |
| host_wd7 | input | 1 | Bit 7 of the host write data |
| card_rdy | input | 1 | Card ready (1) or busy (0) |
| host_irq_n | output | 1 | Active-low card-inserted interrupt |
| host_rdy | output | 1 | Ready indication toward host |
| card_addr | output | 11 | Card address |
| card_cs_n | output | 2 | Active-low card selects |
| card_oe_n | output | 1 | Active-low output enable |
| card_we_n | output | 1 | Active-low write enable |
| card_iord_n | output | 1 | Active-low I/O read strobe |
| card_iowr_n | output | 1 | Active-low I/O write strobe |
| card_reg_n | output | 1 | 1 common memory, 0 attribute or I/O |
| card_reset | output | 1 | Card reset, active high |

## Verification
The assertions assume that the host holds host_cmd, host_addr, io_mode, host_wd7 and host_rst steady from before the acknowledge rise until the update has landed. They also assume that acknowledge stays high, and then low, for at least three clocks, so that every edge is seen once. The stimulus changes these inputs only on falling clock edges. It keeps each acknowledge level for five or more clocks, and it alters command fields only while acknowledge is low. The one exception is the hold test, which changes the command fields with no acknowledge pulse at all.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  localparam int ADDR_W = 11;
  localparam logic [ADDR_W-1:0] CFG_BASE = 11'h200;

  localparam logic [3:0] CMD_NOP    = 4'd0;
  localparam logic [3:0] CMD_RDB    = 4'd1;
  localparam logic [3:0] CMD_RDW    = 4'd2;
  localparam logic [3:0] CMD_WRB    = 4'd3;
  localparam logic [3:0] CMD_WRW    = 4'd4;
  localparam logic [3:0] CMD_OPT_RD = 4'd5;
  localparam logic [3:0] CMD_OPT_WR = 4'd6;
  localparam logic [3:0] CMD_STS_RD = 4'd7;
  localparam logic [3:0] CMD_STS_WR = 4'd8;
  localparam logic [3:0] CMD_PIN_RD = 4'd9;
  localparam logic [3:0] CMD_PIN_WR = 4'd10;

  typedef struct packed {
    logic              rst;
    logic [1:0]        cs_n;
    logic              oe_n;
    logic              we_n;
    logic              iord_n;
    logic              iowr_n;
    logic              reg_n;
    logic [ADDR_W-1:0] addr;
  } strb_t;

  localparam strb_t STRB_IDLE = '{rst: 1'b0, cs_n: 2'b11, oe_n: 1'b1, we_n: 1'b1,
                                  iord_n: 1'b1, iowr_n: 1'b1, reg_n: 1'b1, addr: '0};
endpackage

// File: rtl/cfb_sync.sv
module cfb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= rst_val;
        else        chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= rst_val;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfb_decode.sv
module cfb_decode
  import cfb_pkg::*;
(
  input  logic [3:0]        cmd,
  input  logic              io_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wd7,
  output strb_t             nxt,
  output logic              sw_rst_write
);
  logic is_wr, is_word;

  always_comb begin
    nxt          = STRB_IDLE;
    sw_rst_write = 1'b0;
    is_wr        = (cmd == CMD_WRB) || (cmd == CMD_WRW);
    is_word      = (cmd == CMD_RDW) || (cmd == CMD_WRW);
    case (cmd)
      CMD_RDB, CMD_RDW, CMD_WRB, CMD_WRW: begin
        nxt.cs_n  = is_word ? 2'b00 : 2'b10;
        nxt.addr  = is_word ? {addr[ADDR_W-1:1], 1'b0} : addr;
        nxt.reg_n = ~io_mode;
        if (io_mode) begin
          nxt.iord_n = is_wr;
          nxt.iowr_n = ~is_wr;
        end else begin
          nxt.oe_n = is_wr;
          nxt.we_n = ~is_wr;
        end
      end
      CMD_OPT_RD, CMD_OPT_WR, CMD_STS_RD, CMD_STS_WR, CMD_PIN_RD, CMD_PIN_WR: begin
        nxt.cs_n  = 2'b10;
        nxt.reg_n = 1'b0;
        // even codes are writes, odd codes are reads
        nxt.oe_n  = ~cmd[0];
        nxt.we_n  = cmd[0];
        case (cmd)
          CMD_OPT_RD, CMD_OPT_WR: nxt.addr = CFG_BASE;
          CMD_STS_RD, CMD_STS_WR: nxt.addr = CFG_BASE + 11'd2;
          default:                nxt.addr = CFG_BASE + 11'd4;
        endcase
        sw_rst_write = (cmd == CMD_OPT_WR) && wd7;
      end
      default: nxt = STRB_IDLE;
    endcase
  end
endmodule

// File: rtl/cfb_outreg.sv
module cfb_outreg
  import cfb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  live,
  input  logic  fire,
  input  logic  rst_req,
  input  strb_t nxt,
  output strb_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= STRB_IDLE;
    else if (!live)      q <= STRB_IDLE;
    else if (fire) begin
      if (rst_req) begin
        q     <= STRB_IDLE;
        q.rst <= 1'b1;
      end else begin
        q <= nxt;
      end
    end
  end

  // R3
  hold_between_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !fire) |=> $stable(q));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~q.oe_n, ~q.we_n, ~q.iord_n, ~q.iowr_n}) <= 1);

  // R4
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q.rst |-> (q.cs_n == 2'b11 && q.oe_n && q.we_n && q.iord_n && q.iowr_n));

  // R7
  io_strobe_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q.iord_n || !q.iowr_n) |-> !q.reg_n);

  // R12
  no_card_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (q == STRB_IDLE));
endmodule

// File: rtl/cfb_bridge.sv
module cfb_bridge
  import cfb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic [1:0]        card_det_n,
  input  logic              host_ack,
  input  logic [3:0]        host_cmd,
  input  logic [1:0]        host_rst,
  input  logic              io_mode,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wd7,
  input  logic              card_rdy,
  output logic              host_irq_n,
  output logic              host_rdy,
  output logic [ADDR_W-1:0] card_addr,
  output logic [1:0]        card_cs_n,
  output logic              card_oe_n,
  output logic              card_we_n,
  output logic              card_iord_n,
  output logic              card_iowr_n,
  output logic              card_reg_n,
  output logic              card_reset
);
  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] sync_q;
  logic              ack_s, ack_prev, rdy_s, seated;
  logic [1:0]        det_s;
  logic              live, fire, rst_req, sw_pend, sw_rst_write;
  strb_t             nxt, cur;

  cfb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_val(4'b0110),
    .d({host_ack, card_det_n, card_rdy}), .q(sync_q)
  );
  assign {ack_s, det_s, rdy_s} = sync_q;
  assign seated  = (det_s == 2'b00);
  assign live    = host_en && seated;
  assign fire    = live && ack_s && !ack_prev;
  assign rst_req = (|host_rst) || sw_pend;

  cfb_decode u_dec (
    .cmd(host_cmd), .io_mode(io_mode), .addr(host_addr), .wd7(host_wd7),
    .nxt(nxt), .sw_rst_write(sw_rst_write)
  );

  cfb_outreg u_out (
    .clk(clk), .rst_n(rst_n), .live(live), .fire(fire),
    .rst_req(rst_req), .nxt(nxt), .q(cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev   <= 1'b0;
      sw_pend    <= 1'b0;
      host_irq_n <= 1'b1;
      host_rdy   <= 1'b0;
    end else begin
      ack_prev   <= ack_s;
      host_irq_n <= !live;
      host_rdy   <= live && rdy_s && !cur.rst;
      if (!live)     sw_pend <= 1'b0;
      else if (fire) sw_pend <= !rst_req && sw_rst_write;
    end
  end

  assign card_addr   = cur.addr;
  assign card_cs_n   = cur.cs_n;
  assign card_oe_n   = cur.oe_n;
  assign card_we_n   = cur.we_n;
  assign card_iord_n = cur.iord_n;
  assign card_iowr_n = cur.iowr_n;
  assign card_reg_n  = cur.reg_n;
  assign card_reset  = cur.rst;

  // R2
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq_n |-> $past(host_en));

  // R11
  rdy_low_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_reset |=> !host_rdy);

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |=> (host_irq_n && !host_rdy && !card_reset));
endmodule

// File: tb/cfb_bridge_tb_top.sv
module cfb_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_en = 1'b0;
  logic [1:0]  card_det_n = 2'b11;
  logic        host_ack = 1'b0;
  logic [3:0]  host_cmd = 4'd0;
  logic [1:0]  host_rst = 2'b00;
  logic        io_mode = 1'b0;
  logic [10:0] host_addr = '0;
  logic        host_wd7 = 1'b0;
  logic        card_rdy = 1'b0;
  logic        host_irq_n, host_rdy, card_oe_n, card_we_n, card_iord_n, card_iowr_n;
  logic        card_reg_n, card_reset;
  logic [10:0] card_addr;
  logic [1:0]  card_cs_n;

  int n_chk = 0;
  int n_bad = 0;
  logic tb_pend = 1'b0;
  logic [18:0] exp_q [$];
  int          req_q [$];
  event        mon_ev;

  localparam logic [18:0] IDLE_V = {1'b0, 2'b11, 5'b11111, 11'd0};

  always #2.5 clk = ~clk;

  cfb_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .card_det_n(card_det_n),
    .host_ack(host_ack), .host_cmd(host_cmd), .host_rst(host_rst),
    .io_mode(io_mode), .host_addr(host_addr), .host_wd7(host_wd7),
    .card_rdy(card_rdy), .host_irq_n(host_irq_n), .host_rdy(host_rdy),
    .card_addr(card_addr), .card_cs_n(card_cs_n), .card_oe_n(card_oe_n),
    .card_we_n(card_we_n), .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n),
    .card_reg_n(card_reg_n), .card_reset(card_reset)
  );

  function automatic logic [18:0] got_v();
    return {card_reset, card_cs_n, card_oe_n, card_we_n, card_iord_n,
            card_iowr_n, card_reg_n, card_addr};
  endfunction

  // expected outputs from the requirement tables
  function automatic logic [18:0] model(input logic [3:0] c, input logic [10:0] a,
                                        input logic m, input logic rq);
    logic [1:0] cs; logic oe, we, ir, iw, rg; logic [10:0] ad;
    if (rq) return {1'b1, 2'b11, 5'b11111, 11'd0};
    cs = 2'b11; oe = 1; we = 1; ir = 1; iw = 1; rg = 1; ad = 0;
    if (c >= 1 && c <= 4) begin
      cs = (c == 2 || c == 4) ? 2'b00 : 2'b10;
      ad = (c == 2 || c == 4) ? (a & 11'h7FE) : a;
      rg = !m;
      if (m) begin ir = !(c <= 2); iw = (c <= 2); end
      else   begin oe = !(c <= 2); we = (c <= 2); end
    end else if (c >= 5 && c <= 10) begin
      cs = 2'b10; rg = 0;
      ad = (c <= 6) ? 11'h200 : (c <= 8) ? 11'h202 : 11'h204;
      oe = (c % 2 == 0); we = (c % 2 == 1);
    end
    return {1'b0, cs, oe, we, ir, iw, rg, ad};
  endfunction

  task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one acknowledged operation, expectation pushed to scoreboard
  task automatic do_op(input int r, input logic [3:0] c, input logic [10:0] a,
                       input logic m, input logic w7, input logic [1:0] hr);
    logic rq;
    @(negedge clk);
    host_cmd = c; host_addr = a; io_mode = m; host_wd7 = w7; host_rst = hr;
    rq = (hr != 0) || tb_pend;
    exp_q.push_back(model(c, a, m, rq));
    req_q.push_back(r);
    tb_pend = !rq && (c == 4'd6) && w7;
    wait_n(1);
    host_ack = 1'b1;
    wait_n(5);
    ->mon_ev;
    wait_n(1);
    host_ack = 1'b0;
    host_rst = 2'b00;
    wait_n(5);
  endtask

  // monitor: compare outputs against the queue
  initial begin
    forever begin
      @(mon_ev);
      check(req_q.pop_front(), {13'd0, got_v()}, {13'd0, exp_q.pop_front()});
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [18:0] held;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset / disabled state
    check(1, {host_irq_n, host_rdy}, 2'b10);
    check(1, {13'd0, got_v()}, {13'd0, IDLE_V});
    card_det_n = 2'b00; card_rdy = 1'b1;
    wait_n(5);
    check(1, {host_irq_n, host_rdy}, 2'b10);
    host_cmd = 4'd1; host_addr = 11'h055;
    host_ack = 1'b1; wait_n(5); host_ack = 1'b0; wait_n(5);
    check(1, {13'd0, got_v()}, {13'd0, IDLE_V});
    // R2 insertion interrupt
    host_en = 1'b1; wait_n(5);
    check(2, {31'd0, host_irq_n}, 0);
    check(11, {31'd0, host_rdy}, 1);
    card_rdy = 1'b0; wait_n(5);
    check(11, {31'd0, host_rdy}, 0);
    card_rdy = 1'b1;
    // R12 partial insertion
    card_det_n = 2'b01; wait_n(5);
    check(2, {31'd0, host_irq_n}, 1);
    check(11, {31'd0, host_rdy}, 0);
    host_cmd = 4'd2; host_ack = 1'b1; wait_n(5); host_ack = 1'b0; wait_n(5);
    check(12, {13'd0, got_v()}, {13'd0, IDLE_V});
    card_det_n = 2'b00; wait_n(5);
    check(2, {31'd0, host_irq_n}, 0);
    // R6 R8 memory mode
    do_op(6, 4'd1, 11'h123, 1'b0, 1'b0, 2'b00);
    do_op(8, 4'd4, 11'h455, 1'b0, 1'b0, 2'b00);
    do_op(8, 4'd2, 11'h7FF, 1'b0, 1'b0, 2'b00);
    do_op(6, 4'd3, 11'h001, 1'b0, 1'b0, 2'b00);
    // R7 I/O mode
    do_op(7, 4'd1, 11'h3F1, 1'b1, 1'b0, 2'b00);
    do_op(7, 4'd4, 11'h2A3, 1'b1, 1'b0, 2'b00);
    do_op(7, 4'd3, 11'h010, 1'b1, 1'b0, 2'b00);
    // R9 configuration registers
    do_op(9, 4'd5, 11'h0AA, 1'b1, 1'b0, 2'b00);
    do_op(9, 4'd7, 11'h0AA, 1'b0, 1'b0, 2'b00);
    do_op(9, 4'd8, 11'h0AA, 1'b1, 1'b0, 2'b00);
    do_op(9, 4'd9, 11'h0AA, 1'b0, 1'b0, 2'b00);
    do_op(9, 4'd10, 11'h0AA, 1'b1, 1'b0, 2'b00);
    // R10 no-op and reserved codes
    do_op(10, 4'd0, 11'h123, 1'b0, 1'b0, 2'b00);
    do_op(10, 4'd13, 11'h123, 1'b1, 1'b0, 2'b00);
    // R3 hold between acknowledges
    do_op(3, 4'd2, 11'h246, 1'b0, 1'b0, 2'b00);
    held = got_v();
    host_cmd = 4'd3; host_addr = 11'h111; io_mode = 1'b1;
    wait_n(6);
    check(3, {13'd0, got_v()}, {13'd0, held});
    // R4 hardware and software reset requests
    do_op(4, 4'd1, 11'h100, 1'b0, 1'b0, 2'b01);
    check(11, {31'd0, host_rdy}, 0);
    do_op(4, 4'd0, 11'h000, 1'b0, 1'b0, 2'b00);
    do_op(4, 4'd3, 11'h100, 1'b1, 1'b0, 2'b10);
    do_op(4, 4'd1, 11'h005, 1'b0, 1'b0, 2'b00);
    // R5 software reset by option register write
    do_op(5, 4'd6, 11'h000, 1'b0, 1'b1, 2'b00);
    do_op(5, 4'd1, 11'h077, 1'b0, 1'b0, 2'b00);
    do_op(5, 4'd1, 11'h077, 1'b0, 1'b0, 2'b00);
    do_op(5, 4'd6, 11'h000, 1'b1, 1'b0, 2'b00);
    do_op(5, 4'd2, 11'h078, 1'b1, 1'b0, 2'b00);
    // R1 disabling forces idle outputs
    host_en = 1'b0; wait_n(5);
    check(1, {13'd0, got_v()}, {13'd0, IDLE_V});
    check(1, {host_irq_n, host_rdy}, 2'b10);
    wait_n(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule